// File: doc/BRIEF.md
# SPI Receive Status and Overflow Controller

This block holds the receive-side status of an 8-bit serial peripheral. A shifter, which lies outside the block, pulses a completion strobe together with the byte it has just assembled. The block decides whether that byte is kept in a one-deep data buffer, counted as an overrun, or dropped. It also keeps the two interrupt enables and raises the receive and error interrupt requests.

The processor side has three single-cycle strobes: a status read, a data read and a control write. A flag is cleared by a two-step sequence. A status read that sees the flag set arms the clear, and the next access clears the flag only if that access is a data read. While an overrun is pending, every new byte is dropped and no new receive interrupt can appear. Software that never checks the overrun flag will therefore lose data without noticing.

The byte input has no valid/ready handshake, because the shifter cannot be stalled. A strobe that arrives while the buffer is occupied cannot apply back-pressure, so the block records an overrun instead. The read data outputs are combinational views of registers and are meant to be sampled in the same cycle as their strobe.

Top module: `spi_rx_status`

## Requirements
- R1: A synchronous active-high reset clears both flags, both enables, the armed state and the data buffer, so every output reads zero.
- R2: A completion strobe that arrives while both flags are clear stores the byte in the buffer and sets receive-full in the next cycle.
- R3: A completion strobe that arrives while receive-full is set and no clear is taking effect sets the overrun flag and discards the byte, so the buffer is unchanged.
- R4: While the overrun flag is set and no clear of it is taking effect, a completion strobe is discarded. Neither the buffer nor receive-full changes.
- R5: Receive-full clears only on a data read whose preceding access was a status read that returned receive-full set. A data read that is not armed leaves the flag set.
- R6: Overrun clears only on a data read whose preceding access was a status read that returned overrun set. A data read that clears receive-full leaves an overrun that was raised after the status read.
- R7: A control write between the status read and the data read cancels the armed state.
- R8: rx_irq is high exactly when receive-full and the receive enable are both set. err_irq is high exactly when overrun and the error enable are both set.
- R9: When a completion strobe and a data read that clears flags fall in the same cycle, the clear takes effect first and the byte is then accepted normally.
- R10: The status word carries receive-full at bit 7, overrun at bit 6, the error enable at bit 1 and the receive enable at bit 0, and reads zero elsewhere. A control write loads bit 1 of ctrl_wdata into the error enable and bit 0 into the receive enable.
- R11: A status read and a data read in the same cycle act as a data read that uses the earlier armed state. That cycle leaves nothing armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_done | input | 1 | Byte-complete strobe from the shifter |
| rx_byte | input | DATA_W | Byte delivered with rx_done |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ctrl_wr | input | 1 | Enable register write strobe |
| ctrl_wdata | input | 2 | {error enable, receive enable} |
| stat_rdata | output | 8 | Status word |
| data_rdata | output | DATA_W | Buffered receive byte |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is the missed overrun. A status read arms only receive-full, then a new byte raises overrun before the data read arrives. The data read clears receive-full and leaves overrun set, and every later byte is then dropped silently. A directed sequence drives exactly that order and then checks that a further byte neither sets receive-full nor reaches the buffer. Random traffic with dense strobes also produces same-cycle clear and arrival, as well as cancelled arms.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
  localparam int STAT_W    = 8;
  localparam int FULL_BIT  = 7;
  localparam int OVF_BIT   = 6;
  localparam int ERRIE_BIT = 1;
  localparam int RXIE_BIT  = 0;

  typedef struct packed {
    logic full;
    logic ovf;
  } rx_flags_t;
endpackage

// File: rtl/spi_rxs_arm.sv
module spi_rxs_arm
  import spi_rxs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stat_rd,
  input  logic      data_rd,
  input  logic      ctrl_wr,
  input  rx_flags_t cur,
  output rx_flags_t armed,
  output rx_flags_t clr
);
  logic any_access;
  assign any_access = stat_rd | data_rd | ctrl_wr;

  // A data read consumes whatever the previous access armed.
  assign clr = data_rd ? armed : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= '0;
    end else if (any_access) begin
      if (stat_rd && !data_rd && !ctrl_wr) armed <= cur;
      else                                 armed <= '0;
    end
  end
endmodule

// File: rtl/spi_rxs_flags.sv
module spi_rxs_flags
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  rx_flags_t         clr,
  output rx_flags_t         flags,
  output logic [DATA_W-1:0] data_q
);
  rx_flags_t kept;
  rx_flags_t nxt;
  logic      take;

  // The clear is applied before the arriving byte is judged.
  always_comb begin
    kept.full = flags.full & ~clr.full;
    kept.ovf  = flags.ovf  & ~clr.ovf;
    nxt  = kept;
    take = 1'b0;
    if (rx_done) begin
      if (kept.ovf) begin
        nxt = kept;
      end else if (kept.full) begin
        nxt.ovf = 1'b1;
      end else begin
        nxt.full = 1'b1;
        take     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      data_q <= '0;
    end else begin
      flags <= nxt;
      if (take) data_q <= rx_byte;
    end
  end
endmodule

// File: rtl/spi_rxs_regs.sv
module spi_rxs_regs
  import spi_rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [1:0]        ctrl_wdata,
  input  rx_flags_t         flags,
  output logic [STAT_W-1:0] stat_word,
  output logic              rx_irq,
  output logic              err_irq
);
  logic rx_en;
  logic err_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en  <= 1'b0;
      err_en <= 1'b0;
    end else if (ctrl_wr) begin
      rx_en  <= ctrl_wdata[0];
      err_en <= ctrl_wdata[1];
    end
  end

  always_comb begin
    stat_word            = '0;
    stat_word[FULL_BIT]  = flags.full;
    stat_word[OVF_BIT]   = flags.ovf;
    stat_word[ERRIE_BIT] = err_en;
    stat_word[RXIE_BIT]  = rx_en;
  end

  assign rx_irq  = flags.full & rx_en;
  assign err_irq = flags.ovf  & err_en;
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  input  logic [1:0]        ctrl_wdata,
  output logic [7:0]        stat_rdata,
  output logic [DATA_W-1:0] data_rdata,
  output logic              rx_irq,
  output logic              err_irq
);
  rx_flags_t flags;
  rx_flags_t armed;
  rx_flags_t clr;
  logic      arm_full;
  logic      arm_ovf;

  assign arm_full = armed.full;
  assign arm_ovf  = armed.ovf;

  spi_rxs_arm u_arm (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd),
    .ctrl_wr(ctrl_wr), .cur(flags), .armed(armed), .clr(clr)
  );

  spi_rxs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte),
    .clr(clr), .flags(flags), .data_q(data_rdata)
  );

  spi_rxs_regs u_regs (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .flags(flags), .stat_word(stat_rdata), .rx_irq(rx_irq), .err_irq(err_irq)
  );
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_done,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              ctrl_wr,
  input logic [7:0]        stat_rdata,
  input logic [DATA_W-1:0] data_rdata,
  input logic              rx_irq,
  input logic              err_irq,
  input logic              arm_full,
  input logic              arm_ovf
);
  logic full, ovf;
  assign full = stat_rdata[7];
  assign ovf  = stat_rdata[6];

  a_r3_overflow: assert property (@(posedge clk) disable iff (rst)
    full && !ovf && rx_done && !data_rd |=> ovf && full && $stable(data_rdata));

  a_r4_drop_while_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf && rx_done && !data_rd |=> ovf && $stable(data_rdata) && (full == $past(full)));

  a_r5_unarmed_keeps_full: assert property (@(posedge clk) disable iff (rst)
    full && !(data_rd && arm_full) |=> full);

  a_r6_unarmed_keeps_ovf: assert property (@(posedge clk) disable iff (rst)
    ovf && !(data_rd && arm_ovf) |=> ovf);

  a_r7_ctrl_disarms: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !arm_full && !arm_ovf);

  a_r8_rx_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> full && stat_rdata[0]);

  a_r8_err_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> ovf && stat_rdata[1]);

  a_r11_dual_read_disarms: assert property (@(posedge clk) disable iff (rst)
    stat_rd && data_rd |=> !arm_full && !arm_ovf);
endmodule

bind spi_rx_status spi_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_done(rx_done), .stat_rd(stat_rd),
  .data_rd(data_rd), .ctrl_wr(ctrl_wr), .stat_rdata(stat_rdata),
  .data_rdata(data_rdata), .rx_irq(rx_irq), .err_irq(err_irq),
  .arm_full(arm_full), .arm_ovf(arm_ovf)
);

// File: tb/spi_rx_status_tb.sv
`timescale 1ns/1ps
module spi_rx_status_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_done = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          stat_rd = 1'b0, data_rd = 1'b0, ctrl_wr = 1'b0;
  logic [1:0]    ctrl_wdata = '0;
  logic [7:0]    stat_rdata;
  logic [DW-1:0] data_rdata;
  logic          rx_irq, err_irq;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  bit m_full, m_ovf, m_af, m_ao, m_rxie, m_errie;
  logic [DW-1:0] m_buf;

  always #10 clk = ~clk;

  spi_rx_status #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte),
    .stat_rd(stat_rd), .data_rd(data_rd), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .stat_rdata(stat_rdata), .data_rdata(data_rdata),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  function automatic logic [7:0] exp_stat();
    return {m_full, m_ovf, 4'b0, m_errie, m_rxie};
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_full = 0; m_ovf = 0; m_af = 0; m_ao = 0; m_rxie = 0; m_errie = 0; m_buf = '0;
  endtask

  // Next-state computed from the requirements.
  task automatic model_step(bit rd, logic [DW-1:0] b, bit sr, bit dr, bit cw, logic [1:0] wd);
    bit cf, co, kf, ko;
    cf = dr && m_af;                 // R5
    co = dr && m_ao;                 // R6
    kf = m_full && !cf;
    ko = m_ovf && !co;
    if (rd) begin                    // R9: clear before arrival
      if (ko) ;                      // R4
      else if (kf) ko = 1;           // R3
      else begin kf = 1; m_buf = b; end  // R2
    end
    if (sr || dr || cw) begin        // R7, R11
      if (sr && !dr && !cw) begin m_af = m_full; m_ao = m_ovf; end
      else begin m_af = 0; m_ao = 0; end
    end
    if (cw) begin m_rxie = wd[0]; m_errie = wd[1]; end  // R10
    m_full = kf; m_ovf = ko;
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic step(bit rd, logic [DW-1:0] b, bit sr, bit dr, bit cw, logic [1:0] wd);
    rx_done = rd; rx_byte = b; stat_rd = sr; data_rd = dr; ctrl_wr = cw; ctrl_wdata = wd;
    model_step(rd, b, sr, dr, cw, wd);
    @(negedge clk);
    rx_done = 0; stat_rd = 0; data_rd = 0; ctrl_wr = 0;
  endtask

  task automatic check_all(string tag);
    cmp({tag, " stat"}, 32'(stat_rdata), 32'(exp_stat()));
    cmp({tag, " data"}, 32'(data_rdata), 32'(m_buf));
    cmp({tag, " irq"},  32'({rx_irq, err_irq}),
        32'({m_full && m_rxie, m_ovf && m_errie}));   // R8
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      vec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk);
    do_reset();
    check_all("R1 reset");

    step(0, 0, 0, 0, 1, 2'b11);
    cmp("R10 enables", 32'(stat_rdata[1:0]), 32'd3);
    step(1, 8'hA5, 0, 0, 0, 0);
    cmp("R2 full set", 32'(stat_rdata[7]), 1);
    cmp("R2 buffer", 32'(data_rdata), 32'hA5);
    cmp("R8 rx_irq", 32'(rx_irq), 1);
    step(0, 0, 0, 1, 0, 0);
    cmp("R5 unarmed read keeps full", 32'(stat_rdata[7]), 1);
    step(1, 8'h3C, 0, 0, 0, 0);
    cmp("R3 overrun set", 32'(stat_rdata[7:6]), 32'b11);
    cmp("R3 buffer kept", 32'(data_rdata), 32'hA5);
    cmp("R8 err_irq", 32'(err_irq), 1);
    check_all("R3 model");

    // Missed overrun: ovf appears between status and data reads.
    do_reset();
    step(1, 8'h11, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    cmp("R6 full cleared, ovf kept", 32'(stat_rdata[7:6]), 32'b01);
    step(1, 8'h33, 0, 0, 0, 0);
    cmp("R4 dropped byte", 32'(stat_rdata[7:6]), 32'b01);
    cmp("R4 buffer kept", 32'(data_rdata), 32'h11);
    // Cancelled arm.
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 2'b00);
    step(0, 0, 0, 1, 0, 0);
    cmp("R7 arm cancelled", 32'(stat_rdata[6]), 1);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    cmp("R6 ovf cleared", 32'(stat_rdata[7:6]), 0);
    // Same-cycle clear and arrival.
    step(1, 8'h44, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(1, 8'h55, 0, 1, 0, 0);
    cmp("R9 flags", 32'(stat_rdata[7:6]), 32'b10);
    cmp("R9 buffer", 32'(data_rdata), 32'h55);
    // Simultaneous status and data read.
    step(0, 0, 1, 1, 0, 0);
    cmp("R11 unarmed dual read", 32'(stat_rdata[7]), 1);
    step(0, 0, 0, 1, 0, 0);
    cmp("R11 left unarmed", 32'(stat_rdata[7]), 1);
    check_all("R11 model");

    // Random traffic against the model.
    for (int i = 0; i < 4000; i++) begin
      bit rd, sr, dr, cw;
      rd = ($urandom % 10) < 3;
      sr = ($urandom % 10) < 3;
      dr = ($urandom % 10) < 3;
      cw = ($urandom % 20) == 0;
      step(rd, DW'($urandom), sr, dr, cw, 2'($urandom));
      check_all("R2 random");
      if (($urandom % 500) == 0) begin
        do_reset();
        check_all("R1 random reset");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule